// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and a calendar in eight packed BCD registers. It counts hundredths of seconds, seconds, minutes, hours, day of week, date, month and year. A one-cycle strobe from an external divider advances the count by one hundredth of a second. Every carry ripples through the chain in the same cycle, so a single strobe can move the whole calendar forward, as it does at a year boundary.

The hours register works in either 24-hour or 12-hour format, and in 12-hour format it carries a PM flag. Month lengths and leap years set the last date of each month. The day-of-week register also holds two control bits. One bit stops timekeeping. The other is a reset-enable flag that the block stores and returns unchanged. A parallel load writes all eight registers in one clock and takes priority over a strobe in the same cycle. The complete register set is always visible on a snapshot output.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the snapshot reads hundredths 00, seconds 00, minutes 00, hours 00 in 24-hour format, day register 0x31 (stop bit set, reset-enable bit set, day 1), date 01, month 01 and year 00.
- R2: Register k sits in snapshot bits [8k+7:8k], in this order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. A load stores every register in the cycle after it is asserted, ANDed with these keep masks: 0xFF, 0x7F, 0x7F, 0xBF, 0x37, 0x3F, 0x1F, 0xFF. Masked bits always read 0.
- R3: When a load and a tick arrive in the same cycle, the loaded value is stored and the tick is dropped.
- R4: While day-register bit 5 is 1, ticks change nothing. While it is 0, each tick advances the time.
- R5: Each tick changes the hundredths register. Hundredths wrap from 99 to 00 and carry into seconds. Seconds and minutes wrap from 59 to 00 and carry onward. With no tick and no load, nothing changes.
- R6: With hours bit 7 = 0 (24-hour format, bits 5:4 are the tens digit), hours count 00 to 23. Hours move 09 to 10 and 19 to 20, and 23 wraps to 00 with a carry into the date.
- R7: With hours bit 7 = 1 (12-hour format, bit 5 = PM, bit 4 = tens digit), hours go from 11 to 12 and toggle PM, and from 12 to 01. The date advances only on the step from 11 PM to 12 AM.
- R8: The date wraps to 01 after day 31 in months 01, 03, 05, 07, 08, 10 and 12, after day 30 in months 04, 06, 09 and 11, and after day 28 in February of a non-leap year. The wrap carries into the month.
- R9: February runs to 29 when the year value is a multiple of 4, and year 00 counts as one.
- R10: A date carry advances the day of week (07 wraps to 01). A month carry from 12 to 01 advances the year, and the year wraps from 99 to 00.
- R11: Counting never changes the hour-format bit (hours bit 7) or the day-register control bits 5:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Hundredth-of-second advance strobe |
| load_i | input | 1 | Parallel load strobe |
| load_time_i | input | 64 | New register set, same layout as the snapshot |
| time_o | output | 64 | Snapshot of all eight registers |

## Verification
The bench aims at the wraps that a design can easily get wrong:
- 11 AM to 12 PM, where a wrong design bumps the date.
- 11 PM to 12 AM, where it misses the date carry.
- 12 to 01, where it shows 13 or 00.
- February 28 and 29 in years 23, 24 and 00. A bad leap test either skips February 29 or leaves it out of year 00.
- April 30, which a design that gives every month 31 days would take to 31.
- A full year rollover from Saturday, December 31, year 99, where any broken link in the carry chain leaves one register stale.

It also loads all-ones values to catch unused bits that are kept. It drives a load and a tick in the same cycle to expose a load that is added to by the tick. It sends ticks while the stop bit is set. Random valid times, biased toward the edge of each field, are checked cycle by cycle against an integer model.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  localparam int NREG   = 8;
  localparam int REG_W  = 8;
  localparam int SNAP_W = NREG * REG_W;

  localparam int IDX_HSEC  = 0;
  localparam int IDX_SEC   = 1;
  localparam int IDX_MIN   = 2;
  localparam int IDX_HOUR  = 3;
  localparam int IDX_DOW   = 4;
  localparam int IDX_DATE  = 5;
  localparam int IDX_MONTH = 6;
  localparam int IDX_YEAR  = 7;

  // Bit positions inside the hours and day registers.
  localparam int HOUR_MODE_BIT = 7;
  localparam int HOUR_PM_BIT   = 5;
  localparam int DOW_STOP_BIT  = 5;
  localparam int DOW_RSTEN_BIT = 4;

  // Storable bits of each register; the other bits always read zero.
  localparam logic [SNAP_W-1:0] KEEP_ALL = {
    8'hFF,  // year
    8'h1F,  // month
    8'h3F,  // date
    8'h37,  // day of week with control bits
    8'hBF,  // hours
    8'h7F,  // minutes
    8'h7F,  // seconds
    8'hFF   // hundredths
  };

  typedef logic [REG_W-1:0] bcd8_t;

  // Add one to a two-digit BCD value (no range wrap).
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    bcd8_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Step a BCD value inside [lo, hi]; values at or above hi go back to lo.
  function automatic bcd8_t bcd_next(input bcd8_t v, input bcd8_t lo, input bcd8_t hi);
    bcd8_t r;
    if (v >= hi) r = lo;
    else         r = bcd_inc(v);
    return r;
  endfunction

  // Ten is 2 mod 4, so the BCD year is a multiple of 4 when 2*tens_lsb + ones is.
  function automatic logic bcd_year_leap(input bcd8_t y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'b00);
  endfunction

  // Last BCD date of the given BCD month.
  function automatic bcd8_t month_last_date(input bcd8_t mo, input logic leap);
    bcd8_t r;
    case (mo)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_bcd_wrap.sv
`timescale 1ns/1ps
module rtc_bcd_wrap
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] LO = 8'h00,
  parameter logic [7:0] HI = 8'h59
) (
  input  logic       en,
  input  logic [7:0] cur,
  output logic [7:0] nxt,
  output logic       carry
);

  logic at_top;

  always_comb begin
    at_top = (cur >= HI);
    carry  = en & at_top;
    if (en) nxt = bcd_next(cur, LO, HI);
    else    nxt = cur;
  end

endmodule

// File: rtl/rtc_hour_step.sv
`timescale 1ns/1ps
module rtc_hour_step
  import rtc_cal_pkg::*;
(
  input  logic       en,
  input  logic [7:0] cur,
  output logic [7:0] nxt,
  output logic       day_carry
);

  logic       mode12;
  logic       pm_q;
  logic       pm_n;
  logic [7:0] h24_v;
  logic [7:0] h12_v;
  logic [7:0] h_n;
  logic       wrap24;
  logic       to_noon;

  always_comb begin
    mode12  = cur[HOUR_MODE_BIT];
    pm_q    = cur[HOUR_PM_BIT];
    h24_v   = {2'b00, cur[5:0]};
    h12_v   = {3'b000, cur[4:0]};
    wrap24  = (h24_v >= 8'h23);
    to_noon = (h12_v == 8'h11);
    pm_n    = pm_q;
    h_n     = 8'h00;

    if (mode12) begin
      if (to_noon)              begin h_n = 8'h12; pm_n = ~pm_q; end
      else if (h12_v >= 8'h12)  h_n = 8'h01;
      else                      h_n = bcd_inc(h12_v);
    end else begin
      if (wrap24) h_n = 8'h00;
      else        h_n = bcd_inc(h24_v);
    end

    if (!en) begin
      nxt       = cur;
      day_carry = 1'b0;
    end else if (mode12) begin
      nxt       = {1'b1, 1'b0, pm_n, h_n[4:0]};
      day_carry = to_noon & pm_q;
    end else begin
      nxt       = {2'b00, h_n[5:0]};
      day_carry = wrap24;
    end
  end

endmodule

// File: rtl/rtc_date_step.sv
`timescale 1ns/1ps
module rtc_date_step
  import rtc_cal_pkg::*;
(
  input  logic       en,
  input  logic [7:0] date_cur,
  input  logic [7:0] month_cur,
  input  logic [7:0] year_cur,
  output logic [7:0] date_nxt,
  output logic       month_carry
);

  logic [7:0] last_d;
  logic       leap;
  logic       at_end;

  always_comb begin
    leap        = bcd_year_leap(year_cur);
    last_d      = month_last_date(month_cur, leap);
    at_end      = (date_cur >= last_d);
    month_carry = en & at_end;
    if (!en)         date_nxt = date_cur;
    else if (at_end) date_nxt = 8'h01;
    else             date_nxt = bcd_inc(date_cur);
  end

endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter logic [7:0] RST_DOW   = 8'h01,
  parameter logic [7:0] RST_DATE  = 8'h01,
  parameter logic [7:0] RST_MONTH = 8'h01,
  parameter logic [7:0] RST_YEAR  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [SNAP_W-1:0] load_time_i,
  output logic [SNAP_W-1:0] time_o
);

  localparam int NSUB = 3;  // hundredths, seconds, minutes share one counter shape
  localparam logic [7:0] RST_DAYREG =
    8'((1 << DOW_STOP_BIT) | (1 << DOW_RSTEN_BIT)) | (RST_DOW & 8'h07);

  logic [NREG-1:0][REG_W-1:0] regs_q;
  logic [NREG-1:0][REG_W-1:0] regs_d;

  logic            run;
  logic            upd_en;
  logic [NSUB:0]   sub_c;
  logic [NSUB-1:0][REG_W-1:0] sub_nxt;
  logic [7:0]      hour_nxt;
  logic            day_c;
  logic [7:0]      date_nxt;
  logic            month_c;
  logic [7:0]      month_nxt;
  logic            year_c;
  logic [7:0]      year_nxt;
  logic [7:0]      dow_cur;
  logic [7:0]      dow_nxt;

  assign run      = tick_i & ~regs_q[IDX_DOW][DOW_STOP_BIT];
  assign sub_c[0] = run;
  assign upd_en   = load_i | run;

  generate
    for (genvar g = 0; g < NSUB; g++) begin : g_sub
      localparam logic [7:0] HI_V = (g == IDX_HSEC) ? 8'h99 : 8'h59;
      rtc_bcd_wrap #(.LO(8'h00), .HI(HI_V)) u_wrap (
        .en    (sub_c[g]),
        .cur   (regs_q[g]),
        .nxt   (sub_nxt[g]),
        .carry (sub_c[g+1])
      );
    end
  endgenerate

  rtc_hour_step u_hour (
    .en        (sub_c[NSUB]),
    .cur       (regs_q[IDX_HOUR]),
    .nxt       (hour_nxt),
    .day_carry (day_c)
  );

  rtc_date_step u_date (
    .en          (day_c),
    .date_cur    (regs_q[IDX_DATE]),
    .month_cur   (regs_q[IDX_MONTH]),
    .year_cur    (regs_q[IDX_YEAR]),
    .date_nxt    (date_nxt),
    .month_carry (month_c)
  );

  rtc_bcd_wrap #(.LO(8'h01), .HI(8'h12)) u_month (
    .en    (month_c),
    .cur   (regs_q[IDX_MONTH]),
    .nxt   (month_nxt),
    .carry (year_c)
  );

  always_comb begin
    dow_cur  = {5'b00000, regs_q[IDX_DOW][2:0]};
    dow_nxt  = day_c  ? bcd_next(dow_cur, 8'h01, 8'h07) : dow_cur;
    year_nxt = year_c ? bcd_next(regs_q[IDX_YEAR], 8'h00, 8'h99) : regs_q[IDX_YEAR];
  end

  // Next-state: load wins over a tick.
  always_comb begin
    regs_d = regs_q;
    if (load_i) begin
      for (int i = 0; i < NREG; i++) begin
        regs_d[i] = load_time_i[i*REG_W +: REG_W] & KEEP_ALL[i*REG_W +: REG_W];
      end
    end else if (run) begin
      for (int i = 0; i < NSUB; i++) begin
        regs_d[i] = sub_nxt[i];
      end
      regs_d[IDX_HOUR]  = hour_nxt;
      regs_d[IDX_DOW]   = {2'b00, regs_q[IDX_DOW][DOW_STOP_BIT],
                           regs_q[IDX_DOW][DOW_RSTEN_BIT], 1'b0, dow_nxt[2:0]};
      regs_d[IDX_DATE]  = date_nxt;
      regs_d[IDX_MONTH] = month_nxt;
      regs_d[IDX_YEAR]  = year_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q[IDX_HSEC]  <= 8'h00;
      regs_q[IDX_SEC]   <= 8'h00;
      regs_q[IDX_MIN]   <= 8'h00;
      regs_q[IDX_HOUR]  <= 8'h00;
      regs_q[IDX_DOW]   <= RST_DAYREG;
      regs_q[IDX_DATE]  <= RST_DATE;
      regs_q[IDX_MONTH] <= RST_MONTH;
      regs_q[IDX_YEAR]  <= RST_YEAR;
    end else if (upd_en) begin
      regs_q <= regs_d;
    end
  end

  assign time_o = regs_q;

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              load_i,
  input logic [SNAP_W-1:0] load_time_i,
  input logic [SNAP_W-1:0] time_o
);

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (time_o == ($past(load_time_i) & KEEP_ALL))); // R3

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((time_o & ~KEEP_ALL) == '0)); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && time_o[IDX_DOW*8 + DOW_STOP_BIT]) |=> $stable(time_o)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(time_o)); // R5

  AST_HSEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && !time_o[IDX_DOW*8 + DOW_STOP_BIT])
      |=> (time_o[7:0] != $past(time_o[7:0]))); // R5

  AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(time_o[IDX_HOUR*8 + HOUR_MODE_BIT])); // R11

  AST_CTRL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(time_o[IDX_DOW*8+5 : IDX_DOW*8+4])); // R11

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .load_i      (load_i),
  .load_time_i (load_time_i),
  .time_o      (time_o)
);

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb;

  localparam logic [63:0] MASK    = 64'hFF1F_3F37_BF7F_7FFF;
  localparam logic [63:0] RST_VAL = 64'h0001_0131_0000_0000;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        load;
  logic [63:0] ld_val;
  logic [63:0] snap;
  logic [63:0] exp_v;
  int          vectors;
  int          fails;
  logic        done;

  rtc_bcd_calendar u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .load_i      (load),
    .load_time_i (ld_val),
    .time_o      (snap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int days_in(input int mo, input int yr);
    case (mo)
      2:             return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction

  // Integer reference of one hundredth-second step.
  function automatic logic [63:0] ref_step(input logic [63:0] s);
    int cs, sc, mn, h24, h12, dw, dt, mo, yr;
    logic m12, pm, c;
    logic [63:0] r;
    cs = b2i(s[7:0]); sc = b2i(s[15:8]); mn = b2i(s[23:16]);
    m12 = s[31];
    if (m12) begin
      h12 = b2i({3'b000, s[28:24]});
      h24 = (h12 % 12) + (s[29] ? 12 : 0);
    end else h24 = b2i({2'b00, s[29:24]});
    dw = int'(s[34:32]); dt = b2i(s[47:40]); mo = b2i(s[55:48]); yr = b2i(s[63:56]);
    c = 1'b0;
    cs++;
    if (cs == 100) begin
      cs = 0; sc++;
      if (sc == 60) begin
        sc = 0; mn++;
        if (mn == 60) begin
          mn = 0; h24++;
          if (h24 == 24) begin h24 = 0; c = 1'b1; end
        end
      end
    end
    if (c) begin
      dw = (dw == 7) ? 1 : dw + 1;
      dt++;
      if (dt > days_in(mo, yr)) begin
        dt = 1; mo++;
        if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
      end
    end
    r = s;
    r[7:0] = i2b(cs); r[15:8] = i2b(sc); r[23:16] = i2b(mn);
    if (m12) begin
      pm  = (h24 >= 12);
      h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
      r[31:24] = {1'b1, 1'b0, pm, i2b(h12)[4:0]};
    end else r[31:24] = i2b(h24);
    r[34:32] = 3'(dw);
    r[47:40] = i2b(dt); r[55:48] = i2b(mo); r[63:56] = i2b(yr);
    return r;
  endfunction

  function automatic logic [63:0] mk(input logic [7:0] hs, input logic [7:0] sc,
                                     input logic [7:0] mn, input logic [7:0] hr,
                                     input logic [7:0] dw, input logic [7:0] dt,
                                     input logic [7:0] mo, input logic [7:0] yr);
    return {yr, mo, dt, dw, hr, mn, sc, hs};
  endfunction

  task automatic check(input string tag);
    vectors++;
    if (snap !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, snap, exp_v);
    end
  endtask

  task automatic drive(input logic t, input logic l, input logic [63:0] v, input string tag);
    tick = t; load = l; ld_val = v;
    @(posedge clk);
    if (l)                   exp_v = v & MASK;
    else if (t && !exp_v[37]) exp_v = ref_step(exp_v);
    @(negedge clk);
    check(tag);
  endtask

  task automatic lit(input logic [63:0] want, input string tag);
    vectors++;
    if (snap !== want) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, snap, want);
    end
  endtask

  // Load a value then apply one tick.
  task automatic edge_case(input logic [63:0] v, input logic [63:0] want, input string tag);
    drive(1'b0, 1'b1, v, tag);
    drive(1'b1, 1'b0, 64'h0, tag);
    lit(want, tag);
  endtask

  function automatic logic [63:0] rand_time();
    int yr, mo, dt, h;
    logic m12;
    logic [7:0] hr, hs, sc, mn;
    yr = int'($urandom % 100); mo = 1 + int'($urandom % 12);
    dt = ($urandom % 3 == 0) ? days_in(mo, yr) : 1 + int'($urandom % days_in(mo, yr));
    m12 = $urandom % 2 == 1;
    if (m12) begin
      h  = ($urandom % 2 == 0) ? 11 : 1 + int'($urandom % 12);
      hr = {1'b1, 1'b0, $urandom % 2 == 1, i2b(h)[4:0]};
    end else begin
      h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      hr = i2b(h);
    end
    hs = i2b(($urandom % 2 == 0) ? 90 + int'($urandom % 10) : int'($urandom % 100));
    sc = i2b(($urandom % 2 == 0) ? 59 : int'($urandom % 60));
    mn = i2b(($urandom % 2 == 0) ? 59 : int'($urandom % 60));
    return mk(hs, sc, mn, hr,
              {2'b00, $urandom % 10 == 0, $urandom % 2 == 1, 1'b0, 3'(1 + $urandom % 7)},
              i2b(dt), i2b(mo), i2b(yr));
  endfunction

  initial begin
    done = 1'b0;
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    vectors = 0; fails = 0;
    rst_n = 1'b0; tick = 1'b0; load = 1'b0; ld_val = '0;
    exp_v = RST_VAL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    lit(RST_VAL, "R1 reset state");

    // R4: stopped after reset, ticks ignored
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 64'h0, "R4 stop bit holds");
    lit(RST_VAL, "R4 stopped value unchanged");

    // R2: masking of unused bits
    drive(1'b0, 1'b1, '1, "R2 all-ones load");
    lit(MASK, "R2 masked bits read zero");

    // R3: load and tick together, load wins
    drive(1'b1, 1'b1, mk(8'h50, 8'h10, 8'h20, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30), "R3 load priority");
    lit(mk(8'h50, 8'h10, 8'h20, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30), "R3 tick dropped");

    // R5 idle hold and simple step
    drive(1'b0, 1'b0, 64'h0, "R5 idle hold");
    drive(1'b1, 1'b0, 64'h0, "R5 hundredth step");
    lit(mk(8'h51, 8'h10, 8'h20, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30), "R5 value after step");

    // R7: 12-hour transitions
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h91, 8'h03, 8'h10, 8'h05, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'hB2, 8'h03, 8'h10, 8'h05, 8'h21), "R7 11AM to 12PM");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'hB1, 8'h03, 8'h10, 8'h05, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'h92, 8'h04, 8'h11, 8'h05, 8'h21), "R7 11PM to 12AM");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h92, 8'h03, 8'h10, 8'h05, 8'h21),
              mk(8'h00, 8'h00, 8'h00, 8'h81, 8'h03, 8'h10, 8'h05, 8'h21), "R7 12 to 01");

    // R6: 24-hour transitions
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h09, 8'h01, 8'h01, 8'h01, 8'h01),
              mk(8'h00, 8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h01), "R6 09 to 10");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h19, 8'h01, 8'h01, 8'h01, 8'h01),
              mk(8'h00, 8'h00, 8'h00, 8'h20, 8'h01, 8'h01, 8'h01, 8'h01), "R6 19 to 20");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h01, 8'h01, 8'h01),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h02, 8'h01, 8'h01), "R6 23 to 00");

    // R8 / R9: month ends
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h23), "R8 Feb 28 non-leap");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h23), "R8 Apr 30");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h23),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h02, 8'h23), "R8 Jan 31");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h24), "R9 Feb 28 leap 24");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h29, 8'h02, 8'h00), "R9 Feb 28 year 00");
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h03, 8'h24), "R9 Feb 29 leap");

    // R10 + R11: full year rollover with control bits kept
    edge_case(mk(8'h99, 8'h59, 8'h59, 8'h23, 8'h17, 8'h31, 8'h12, 8'h99),
              mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h11, 8'h01, 8'h01, 8'h00), "R10 R11 year rollover");

    // Random mix against the integer model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 3) drive(1'b0, 1'b1, rand_time(), "R2 random load");
      else       drive(r < 75, 1'b0, 64'h0, "R5 R8 R10 random step");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule